// File: doc/BRIEF.md
# Virtualization Trap Decision Unit

This block decides, once per cycle, what happens to the instruction or event presented to it. The instruction may run on, or it may trap to the kernel of the current software level, or it may force an exit from a guest to the hypervisor. The block keeps three pieces of state: the privilege level (user or kernel), whether virtualization support is enabled, and whether execution is currently inside a guest (non-root) or in the host (root).

While virtualization is disabled, or while running in root, the unit acts as a plain two-level privilege machine. Privileged work attempted from user level traps into the kernel, and system calls, interrupts and faults also enter the kernel. Inside a guest, the unit adds a second axis. Sensitive instructions, hardware interrupts and faults leave the guest for the hypervisor and record a cause code. System calls and privileged instructions that are not sensitive stay inside the guest and go to its own kernel.

The unit does no instruction decoding. It trusts the class flags it is given, and it leaves the saving of register state to other logic. Every output is registered, so each one reflects the inputs of the previous clock edge.

Top module: `vtrap_unit`

## Requirements
- R1: After synchronous reset the unit is at kernel level (`priv_o`=1), in root (`nonroot_o`=0), with virtualization disabled (`virt_en_o`=0), `exit_reason_o`=0, and `trap_o` and `entry_err_o` low.
- R2: Outside a guest, a valid instruction flagged privileged at user level gives `trap_o`=1 and `trap_tgt_o`=0 (kernel) on the next cycle, and the level becomes kernel. At kernel level the same instruction gives no trap. An unprivileged instruction never traps outside a guest.
- R3: Outside a guest, a system call, a hardware interrupt or a fault each give a trap with target 0 (kernel), set kernel level, keep `nonroot_o` at 0 and leave `exit_reason_o` unchanged.
- R4: A return command (`cmd_ret`) with no trap in the same cycle sets user level without a trap.
- R5: `cmd_virt_on` sets `virt_en_o`. `cmd_virt_off` clears it in root, but is ignored in a guest, where `virt_en_o` stays 1.
- R6: A guest-entry command, when accepted, sets `nonroot_o`=1 and kernel level without a trap. It is accepted only if virtualization is enabled, the unit is in root, and no trap occurs in that cycle.
- R7: A guest-entry command that is not accepted changes no mode and gives a one-cycle `entry_err_o` pulse.
- R8: In a guest, a valid instruction flagged sensitive (privileged or not) exits: `trap_o`=1, `trap_tgt_o`=1 (hypervisor), `nonroot_o`=0, kernel level, `exit_reason_o`=1.
- R9: In a guest, a system call traps to the guest kernel (target 0) and stays in the guest with kernel level. `exit_reason_o` is unchanged.
- R10: In a guest, a hardware interrupt exits to the hypervisor with `exit_reason_o`=2, and a fault exits with `exit_reason_o`=3.
- R11: When several arrive together the order is interrupt, then fault, then system call, then instruction, and only the winner acts. Commands take effect only in cycles without a trap.
- R12: `exit_reason_o` changes only in a cycle with an exit to the hypervisor and holds between exits. `trap_o` is high for exactly one cycle per trapping input.
- R13: In a guest, a privileged instruction that is not sensitive traps to the guest kernel (target 0) from guest user level, and does not trap at guest kernel level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction presented this cycle |
| insn_priv | input | 1 | Instruction is privileged |
| insn_sens | input | 1 | Instruction is sensitive |
| evt_syscall | input | 1 | System call request |
| evt_irq | input | 1 | Hardware interrupt |
| evt_fault | input | 1 | Fault |
| cmd_virt_on | input | 1 | Enable virtualization |
| cmd_virt_off | input | 1 | Disable virtualization |
| cmd_enter | input | 1 | Enter guest (launch or resume) |
| cmd_ret | input | 1 | Return to user level |
| trap_o | output | 1 | One-cycle trap pulse |
| trap_tgt_o | output | 1 | Trap target: 0 kernel, 1 hypervisor |
| priv_o | output | 1 | 1 kernel level, 0 user level |
| nonroot_o | output | 1 | 1 inside a guest |
| virt_en_o | output | 1 | Virtualization enabled |
| exit_reason_o | output | 2 | 0 none, 1 sensitive, 2 interrupt, 3 fault |
| entry_err_o | output | 1 | Guest entry refused |

## Verification
The same instruction classes run in root and in a guest, at both privilege levels. This shows whether the sensitive flag or the privileged flag decides each outcome: an unprivileged sensitive instruction must exit only in a guest, and a privileged one that is not sensitive must stay with the guest kernel. Simultaneous inputs check the priority order. A system call paired with a sensitive instruction tells a guest-kernel trap apart from an exit. Guest entries are tried when disabled, when already inside a guest, and in a trap cycle, to separate the refusal paths from an accepted entry. Idle cycles after an exit show that the cause code holds.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;

    localparam int REASON_W = 2;

    typedef enum logic {
        TGT_KERNEL = 1'b0,
        TGT_HYP    = 1'b1
    } tgt_e;

    typedef enum logic [REASON_W-1:0] {
        RSN_NONE  = 2'd0,
        RSN_SENS  = 2'd1,
        RSN_IRQ   = 2'd2,
        RSN_FAULT = 2'd3
    } reason_e;

    typedef struct packed {
        logic nonroot;
        logic kernel;
        logic en;
    } mode_t;

    typedef struct packed {
        logic    trap;
        tgt_e    tgt;
        logic    leave_guest;
        reason_e reason;
    } verdict_t;

    typedef struct packed {
        logic valid;
        logic priv;
        logic sens;
    } insn_t;

    typedef struct packed {
        logic syscall;
        logic irq;
        logic fault;
    } evt_t;

    function automatic verdict_t exit_to_hyp(reason_e r);
        verdict_t v;
        v.trap        = 1'b1;
        v.tgt         = TGT_HYP;
        v.leave_guest = 1'b1;
        v.reason      = r;
        return v;
    endfunction

    function automatic verdict_t enter_kernel();
        verdict_t v;
        v.trap        = 1'b1;
        v.tgt         = TGT_KERNEL;
        v.leave_guest = 1'b0;
        v.reason      = RSN_NONE;
        return v;
    endfunction

    function automatic verdict_t no_trap();
        verdict_t v;
        v.trap        = 1'b0;
        v.tgt         = TGT_KERNEL;
        v.leave_guest = 1'b0;
        v.reason      = RSN_NONE;
        return v;
    endfunction

endpackage

// File: rtl/vtrap_decide.sv
module vtrap_decide
    import vtrap_pkg::*;
(
    input  mode_t    mode_i,
    input  insn_t    insn_i,
    input  evt_t     evt_i,
    output verdict_t verdict_o
);

    always_comb begin
        verdict_o = no_trap();
        if (evt_i.irq) begin
            verdict_o = mode_i.nonroot ? exit_to_hyp(RSN_IRQ) : enter_kernel();
        end else if (evt_i.fault) begin
            verdict_o = mode_i.nonroot ? exit_to_hyp(RSN_FAULT) : enter_kernel();
        end else if (evt_i.syscall) begin
            verdict_o = enter_kernel();
        end else if (insn_i.valid) begin
            if (mode_i.nonroot && insn_i.sens)
                verdict_o = exit_to_hyp(RSN_SENS);
            else if (insn_i.priv && !mode_i.kernel)
                verdict_o = enter_kernel();
        end
    end

endmodule

// File: rtl/vtrap_mode_ctl.sv
module vtrap_mode_ctl
    import vtrap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict_i,
    input  logic     cmd_virt_on,
    input  logic     cmd_virt_off,
    input  logic     cmd_enter,
    input  logic     cmd_ret,
    output mode_t    mode_o,
    output logic     entry_err_o
);

    mode_t mode_q, mode_d;
    logic  entry_ok, err_d;

    assign entry_ok = cmd_enter && mode_q.en && !mode_q.nonroot && !verdict_i.trap;

    always_comb begin
        mode_d = mode_q;
        err_d  = cmd_enter && !entry_ok;
        if (verdict_i.trap) begin
            mode_d.kernel = 1'b1;
            if (verdict_i.leave_guest)
                mode_d.nonroot = 1'b0;
        end else begin
            if (cmd_virt_on)
                mode_d.en = 1'b1;
            else if (cmd_virt_off && !mode_q.nonroot)
                mode_d.en = 1'b0;
            if (entry_ok) begin
                mode_d.nonroot = 1'b1;
                mode_d.kernel  = 1'b1;
            end else if (cmd_ret) begin
                mode_d.kernel = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '{nonroot: 1'b0, kernel: 1'b1, en: 1'b0};
            entry_err_o <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            entry_err_o <= err_d;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/vtrap_report.sv
module vtrap_report
    import vtrap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict_i,
    output logic     trap_o,
    output tgt_e     tgt_o,
    output reason_e  reason_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_o   <= 1'b0;
            tgt_o    <= TGT_KERNEL;
            reason_o <= RSN_NONE;
        end else begin
            trap_o <= verdict_i.trap;
            tgt_o  <= verdict_i.tgt;
            if (verdict_i.trap && verdict_i.leave_guest)
                reason_o <= verdict_i.reason;
        end
    end

endmodule

// File: rtl/vtrap_unit.sv
module vtrap_unit
    import vtrap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                insn_valid,
    input  logic                insn_priv,
    input  logic                insn_sens,
    input  logic                evt_syscall,
    input  logic                evt_irq,
    input  logic                evt_fault,
    input  logic                cmd_virt_on,
    input  logic                cmd_virt_off,
    input  logic                cmd_enter,
    input  logic                cmd_ret,
    output logic                trap_o,
    output logic                trap_tgt_o,
    output logic                priv_o,
    output logic                nonroot_o,
    output logic                virt_en_o,
    output logic [REASON_W-1:0] exit_reason_o,
    output logic                entry_err_o
);

    mode_t    mode;
    verdict_t verdict;
    insn_t    insn;
    evt_t     evt;
    tgt_e     tgt;
    reason_e  reason;

    assign insn = '{valid: insn_valid, priv: insn_priv, sens: insn_sens};
    assign evt  = '{syscall: evt_syscall, irq: evt_irq, fault: evt_fault};

    vtrap_decide u_decide (
        .mode_i   (mode),
        .insn_i   (insn),
        .evt_i    (evt),
        .verdict_o(verdict)
    );

    vtrap_mode_ctl u_mode (
        .clk         (clk),
        .rst         (rst),
        .verdict_i   (verdict),
        .cmd_virt_on (cmd_virt_on),
        .cmd_virt_off(cmd_virt_off),
        .cmd_enter   (cmd_enter),
        .cmd_ret     (cmd_ret),
        .mode_o      (mode),
        .entry_err_o (entry_err_o)
    );

    vtrap_report u_report (
        .clk      (clk),
        .rst      (rst),
        .verdict_i(verdict),
        .trap_o   (trap_o),
        .tgt_o    (tgt),
        .reason_o (reason)
    );

    assign trap_tgt_o    = tgt;
    assign exit_reason_o = reason;
    assign priv_o        = mode.kernel;
    assign nonroot_o     = mode.nonroot;
    assign virt_en_o     = mode.en;

endmodule

// File: rtl/vtrap_chk.sv
module vtrap_chk (
    input logic       clk,
    input logic       rst,
    input logic       insn_valid,
    input logic       insn_priv,
    input logic       insn_sens,
    input logic       evt_syscall,
    input logic       evt_irq,
    input logic       evt_fault,
    input logic       cmd_virt_on,
    input logic       cmd_virt_off,
    input logic       cmd_enter,
    input logic       cmd_ret,
    input logic       trap_o,
    input logic       trap_tgt_o,
    input logic       priv_o,
    input logic       nonroot_o,
    input logic       virt_en_o,
    input logic [1:0] exit_reason_o,
    input logic       entry_err_o
);

    // R2
    user_priv_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (!nonroot_o && !priv_o && insn_valid && insn_priv && !evt_irq && !evt_fault && !evt_syscall)
        |=> (trap_o && !trap_tgt_o && priv_o));

    // R6
    entry_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nonroot_o) |-> ($past(virt_en_o) && !trap_o));

    // R7
    refused_entry_chk: assert property (@(posedge clk) disable iff (rst)
        entry_err_o |-> !$rose(nonroot_o));

    // R8
    sens_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (nonroot_o && insn_valid && insn_sens && !evt_irq && !evt_fault && !evt_syscall)
        |=> (trap_o && trap_tgt_o && !nonroot_o && exit_reason_o == 2'd1));

    // R9
    guest_syscall_chk: assert property (@(posedge clk) disable iff (rst)
        (nonroot_o && evt_syscall && !evt_irq && !evt_fault)
        |=> (trap_o && !trap_tgt_o && nonroot_o && priv_o && $stable(exit_reason_o)));

    // R10
    guest_irq_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (nonroot_o && evt_irq) |=> (trap_o && trap_tgt_o && !nonroot_o && exit_reason_o == 2'd2));

    // R12
    reason_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(exit_reason_o) |-> (trap_o && trap_tgt_o));

    // R8
    hyp_lands_root_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_o && trap_tgt_o) |-> (!nonroot_o && priv_o));

endmodule

bind vtrap_unit vtrap_chk u_chk (.*);

// File: tb/tb_vtrap_unit.sv
module tb_vtrap_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic insn_valid = 0, insn_priv = 0, insn_sens = 0;
    logic evt_syscall = 0, evt_irq = 0, evt_fault = 0;
    logic cmd_virt_on = 0, cmd_virt_off = 0, cmd_enter = 0, cmd_ret = 0;
    logic       trap_o, trap_tgt_o, priv_o, nonroot_o, virt_en_o, entry_err_o;
    logic [1:0] exit_reason_o;

    always #10 clk = ~clk;

    vtrap_unit dut (.*);

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic m_kern = 1, m_nr = 0, m_en = 0;
    logic [1:0] m_rsn = 0;

    function automatic logic [7:0] observed();
        return {trap_o, trap_tgt_o, priv_o, nonroot_o, virt_en_o, exit_reason_o, entry_err_o};
    endfunction

    // stimulus bits: {vld,prv,sns,sys,irq,flt,on,off,ent,ret}
    task automatic step(input logic [9:0] s, input string req);
        logic t, tg, ex, er, acc;
        logic [1:0] rs;
        item_t it;
        @(negedge clk);
        {insn_valid, insn_priv, insn_sens, evt_syscall, evt_irq, evt_fault,
         cmd_virt_on, cmd_virt_off, cmd_enter, cmd_ret} = s;
        t = 0; tg = 0; ex = 0; rs = 0;
        if (s[5])      begin t = 1; if (m_nr) begin tg = 1; ex = 1; rs = 2; end end
        else if (s[4]) begin t = 1; if (m_nr) begin tg = 1; ex = 1; rs = 3; end end
        else if (s[6]) t = 1;
        else if (s[9]) begin
            if (m_nr && s[7]) begin t = 1; tg = 1; ex = 1; rs = 1; end
            else if (s[8] && !m_kern) t = 1;
        end
        acc = s[1] && m_en && !m_nr && !t;
        er  = s[1] && !acc;
        if (t) begin
            m_kern = 1;
            if (ex) begin m_nr = 0; m_rsn = rs; end
        end else begin
            if (s[3]) m_en = 1;
            else if (s[2] && !m_nr) m_en = 0;
            if (acc) begin m_nr = 1; m_kern = 1; end
            else if (s[0]) m_kern = 0;
        end
        it.exp = {t, tg, m_kern, m_nr, m_en, m_rsn, er};
        it.req = req;
        q.push_back(it);
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (observed() !== it.exp) begin
                errors++;
                $display("FAIL %s: got %b expected %b", it.req, observed(), it.exp);
            end
        end
    end

    localparam logic [9:0] IDLE = 10'b0;
    localparam logic [9:0] RET  = 10'b0000000001;
    localparam logic [9:0] ENT  = 10'b0000000010;
    localparam logic [9:0] OFF  = 10'b0000000100;
    localparam logic [9:0] ON   = 10'b0000001000;
    localparam logic [9:0] FLT  = 10'b0000010000;
    localparam logic [9:0] IRQ  = 10'b0000100000;
    localparam logic [9:0] SYS  = 10'b0001000000;
    localparam logic [9:0] IPRV = 10'b1100000000;
    localparam logic [9:0] ISNS = 10'b1010000000;
    localparam logic [9:0] IPLN = 10'b1000000000;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        checks++;
        if (observed() !== 8'b00100000) begin
            errors++;
            $display("FAIL R1: got %b expected %b", observed(), 8'b00100000);
        end
        // root, disabled
        step(RET, "R4 return to user");
        step(IPRV, "R2 privileged in user traps");
        step(IPRV, "R2 privileged in kernel runs");
        step(RET, "R4 return");
        step(IPLN, "R2 plain insn no trap");
        step(ISNS, "R2 sensitive unprivileged in root no trap");
        step(SYS, "R3 syscall to kernel");
        step(RET, "R4");
        step(IRQ, "R3 irq to kernel");
        step(RET, "R4");
        step(FLT, "R3 fault to kernel");
        step(ENT, "R7 entry while disabled");
        step(ON, "R5 enable");
        step(ENT, "R6 entry accepted");
        step(ENT, "R7 entry while in guest");
        step(OFF, "R5 disable ignored in guest");
        step(RET, "R4 guest user");
        step(IPRV, "R13 privileged non-sensitive in guest user");
        step(IPRV, "R13 privileged in guest kernel runs");
        step(RET, "R4");
        step(SYS, "R9 guest syscall");
        step(SYS | ISNS, "R11 syscall beats sensitive insn");
        step(ISNS, "R8 unprivileged sensitive exits");
        step(IDLE, "R12 reason holds");
        step(IDLE, "R12 trap pulse ends");
        step(ENT, "R6 re-entry");
        step(IRQ | ISNS, "R11 irq beats insn, R10");
        step(ENT, "R6");
        step(FLT, "R10 fault exit");
        step(ENT, "R6");
        step(ISNS | 10'b0100000000, "R8 privileged sensitive exits");
        step(ENT, "R6");
        step(IRQ | FLT, "R11 irq beats fault");
        step(ENT | SYS, "R11 entry in trap cycle refused, R7");
        step(IPLN, "R2 plain insn root kernel");
        step(OFF, "R5 disable in root");
        step(IDLE, "R12 idle");
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule